// File: doc/BRIEF.md
# Read-only serial result port for a single-channel converter

This block is the digital control and two-wire serial slave of a single-channel data converter. It steps through three phases. In the first, a conversion runs. In the second, the block sleeps and holds the finished result. In the third, it shifts that result out to a bus master. The analog front end, the decimation filter and the oscillator are outside the block. They appear here only as a one-cycle completion strobe and a result word. The block in turn asks them to start work with a one-cycle start pulse.

The bus side is a read-only slave on a fixed 7-bit address. It acknowledges its own address only when a finished result is waiting. While a conversion is in progress it answers with a not-acknowledge, so a master can poll it. The block never drives the data line high. It only enables a pull-down, which the pad turns into an open-drain output. Both bus lines pass through a two-flop synchronizer and a stability filter clocked by the system clock, which must run at least 20 times faster than the bus clock.

Top module: `adc_read_port`

## Requirements
- R1: After reset, `conv_start_o` pulses exactly once, `sleep_o` is 0 and `sda_pull_o` is 0.
- R2: A `conv_done_i` pulse during a conversion captures `conv_data_i` and raises `sleep_o`.
- R3: A START followed by the byte 0x29 (address 7'b0010100 with read bit 1), received while `sleep_o` is 1, is acknowledged: SDA is pulled low for the whole ninth clock.
- R4: The same read byte received while a conversion runs is not acknowledged, and the conversion continues until `conv_done_i`.
- R5: A write byte 0x28 or any other address (for example 0x2B) is not acknowledged. `sleep_o`, the held result and the count of start pulses stay unchanged.
- R6: After an acknowledge, the held word is sent as two bytes, bit 15 first. Each bit is placed after an SCL falling edge, and SDA is released during the master's acknowledge slot after each byte.
- R7: When the master's acknowledge slot after the 16th bit ends, one `conv_start_o` pulse is issued and `sleep_o` drops to 0.
- R8: A STOP after an acknowledged read that has not finished issues one `conv_start_o` pulse and drops `sleep_o`.
- R9: A repeated START during read-out issues no start pulse. A new read then acknowledges and returns the same word again.
- R10: While sleeping, changes on `conv_data_i` and extra `conv_done_i` pulses have no effect on the word that is read out.
- R11: Pulses on SCL or SDA shorter than `FILT_LEN` system clock cycles are ignored.
- R12: `sda_pull_o` is 0 whenever the bus is idle, after a not-acknowledge, and during the master's acknowledge slots. It is only ever set after an SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| conv_done_i | input | 1 | One-cycle strobe: the converter has finished |
| conv_data_i | input | DATA_W | Result word from the converter, valid with the strobe |
| sda_pull_o | output | 1 | Enables the open-drain pull-down on SDA |
| conv_start_o | output | 1 | One-cycle request to begin a conversion |
| sleep_o | output | 1 | High while a finished result waits to be read |

## Verification
The bench builds the block with `FILT_LEN` = 4 instead of the default 10, and keeps `DATA_W` = 16 and the fixed address. The short filter allows a bus bit of 48 system cycles, so about thirty full transactions fit easily in the run. The margin between the filter length and a two-cycle SCL spike is also wide enough that injecting spikes into every low phase of a read checks the rejection rule. Bit 15 and bit 7 of the chosen result words are set, so the slave releases SDA at the points where the bench issues a STOP or a repeated START in the middle of a read.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;

  typedef enum logic [2:0] {
    B_IDLE, B_ADDR, B_ACK, B_DATA, B_MACK, B_SKIP
  } bus_st_e;

  typedef enum logic [1:0] {
    C_BUSY, C_SLEEP, C_XMIT
  } conv_st_e;

  // address byte: seven address bits followed by the read flag (1 = read)
  function automatic logic addr_hit(input logic [7:0] rx, input logic [6:0] own);
    return (rx[7:1] == own) && rx[0];
  endfunction

endpackage

// File: rtl/line_filter.sv
`timescale 1ns/1ps
module line_filter #(
  parameter int FILT_LEN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic s1_q, s2_q, filt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (s2_q == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        filt_q <= s2_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt_o = filt_q;

  // R11
  settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(s2_q) == filt_q));

endmodule

// File: rtl/bus_cond.sv
`timescale 1ns/1ps
module bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign start_o = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_o  = scl_f & scl_p & ~sda_p & sda_f;
  assign rise_o  = scl_f & ~scl_p;
  assign fall_o  = ~scl_f & scl_p;

  // R6
  bus_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, stop_o, rise_o, fall_o}));

endmodule

// File: rtl/adc_read_port.sv
`timescale 1ns/1ps
module adc_read_port
  import adc_rd_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int          FILT_LEN = 10,
  parameter logic [6:0]  OWN_ADDR = 7'b0010100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              sda_pull_o,
  output logic              conv_start_o,
  output logic              sleep_o
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [1:0] raw_w, filt_w;
  logic ev_start, ev_stop, ev_rise, ev_fall;

  assign raw_w = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(raw_w[g]), .filt_o(filt_w[g])
    );
  end

  bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_f(filt_w[1]), .sda_f(filt_w[0]),
    .start_o(ev_start), .stop_o(ev_stop), .rise_o(ev_rise), .fall_o(ev_fall)
  );

  function automatic logic bit_below(input logic [DATA_W-1:0] w, input logic [IDX_W-1:0] i);
    return w[i - IDX_W'(1)];
  endfunction

  bus_st_e           bst;
  conv_st_e          cst;
  logic [7:0]        shreg;
  logic [3:0]        bcnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] res_q;
  logic              pull_q, start_q, boot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bst     <= B_IDLE;
      cst     <= C_BUSY;
      shreg   <= '0;
      bcnt    <= '0;
      idx     <= '0;
      res_q   <= '0;
      pull_q  <= 1'b0;
      start_q <= 1'b0;
      boot_q  <= 1'b1;
    end else begin
      start_q <= boot_q;
      boot_q  <= 1'b0;
      if (cst == C_BUSY && conv_done_i) begin
        res_q <= conv_data_i;
        cst   <= C_SLEEP;
      end
      if (ev_start) begin
        bst    <= B_ADDR;
        bcnt   <= '0;
        pull_q <= 1'b0;
        if (cst == C_XMIT) cst <= C_SLEEP;
      end else if (ev_stop) begin
        bst    <= B_IDLE;
        pull_q <= 1'b0;
        if (cst == C_XMIT) begin
          cst     <= C_BUSY;
          start_q <= 1'b1;
        end
      end else begin
        unique case (bst)
          B_ADDR: begin
            if (ev_rise && bcnt != 4'd8) begin
              shreg <= {shreg[6:0], filt_w[0]};
              bcnt  <= bcnt + 1'b1;
            end else if (ev_fall && bcnt == 4'd8) begin
              if (addr_hit(shreg, OWN_ADDR) && cst == C_SLEEP) begin
                pull_q <= 1'b1;
                bst    <= B_ACK;
                cst    <= C_XMIT;
              end else begin
                bst <= B_SKIP;
              end
            end
          end
          B_ACK: if (ev_fall) begin
            pull_q <= ~res_q[DATA_W-1];
            idx    <= IDX_W'(DATA_W - 1);
            bcnt   <= 4'd1;
            bst    <= B_DATA;
          end
          B_DATA: if (ev_fall) begin
            if (bcnt == 4'd8) begin
              pull_q <= 1'b0;
              bst    <= B_MACK;
            end else begin
              pull_q <= ~bit_below(res_q, idx);
              idx    <= idx - 1'b1;
              bcnt   <= bcnt + 1'b1;
            end
          end
          B_MACK: if (ev_fall) begin
            if (idx == '0) begin
              bst     <= B_SKIP;
              cst     <= C_BUSY;
              start_q <= 1'b1;
            end else begin
              pull_q <= ~bit_below(res_q, idx);
              idx    <= idx - 1'b1;
              bcnt   <= 4'd1;
              bst    <= B_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o   = pull_q;
  assign conv_start_o = start_q;
  assign sleep_o      = (cst == C_SLEEP);

  // R12
  pull_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> $past(ev_fall));
  // R12
  pull_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pull_q |-> (bst == B_ACK || bst == B_DATA));
  // R7
  kick_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (cst == C_BUSY));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cst == C_SLEEP && $past(cst == C_SLEEP)) |-> $stable(res_q));
  // R4
  ack_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cst == C_XMIT) |-> $past(cst == C_SLEEP));

endmodule

// File: tb/sim_adc_read_port.sv
`timescale 1ns/1ps
module sim_adc_read_port;
  localparam int Q = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, glitch = 1'b0;
  logic conv_done = 1'b0;
  logic [15:0] conv_data = '0;
  logic sda_pull, conv_start, sleep;
  wire  sda_line = m_sda & ~sda_pull;
  int n_chk = 0, n_err = 0, n_kick = 0;

  always #2.5 clk = ~clk;

  adc_read_port #(.DATA_W(16), .FILT_LEN(4)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .conv_done_i(conv_done), .conv_data_i(conv_data),
    .sda_pull_o(sda_pull), .conv_start_o(conv_start), .sleep_o(sleep)
  );

  always @(posedge clk) if (rst_n && conv_start) n_kick++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0;
  endtask

  task automatic bus_rstart();
    wq(Q); m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic xfer(input logic b, output logic r);
    wq(Q); m_sda = b;
    if (glitch) begin m_scl = 1'b1; wq(2); m_scl = 1'b0; end
    wq(Q); m_scl = 1'b1; wq(Q); r = sda_line; wq(Q); m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) xfer(v[i], r);
    xfer(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic r;
    v = '0;
    for (int i = 0; i < 8; i++) begin xfer(1'b1, r); v = {v[6:0], r}; end
    xfer(~mack, r);
    chk("R12 released in master ack slot", {31'd0, sda_pull}, 32'd0);
  endtask

  task automatic finish_conv(input logic [15:0] v);
    conv_data = v;
    @(negedge clk) conv_done = 1'b1;
    @(negedge clk) conv_done = 1'b0;
    wq(2);
  endtask

  task automatic read_word(output logic ack, output logic [15:0] v);
    logic [7:0] hi, lo;
    v = '0;
    bus_start();
    send_byte(8'h29, ack);
    if (ack) begin
      recv_byte(1'b1, hi);
      recv_byte(1'b0, lo);
      v = {hi, lo};
    end
    bus_stop();
  endtask

  task automatic t_reset();
    wq(20);
    chk("R1 single start pulse", n_kick, 1);
    chk("R1 sleep low", {31'd0, sleep}, 0);
    chk("R1 sda released", {31'd0, sda_pull}, 0);
  endtask

  task automatic t_busy_nak();
    logic ack;
    bus_start(); send_byte(8'h29, ack); bus_stop();
    chk("R4 nak while busy", {31'd0, ack}, 0);
    chk("R4 still converting", {31'd0, sleep}, 0);
    chk("R4 no extra start", n_kick, 1);
    chk("R12 idle after nak", {31'd0, sda_pull}, 0);
  endtask

  task automatic t_done();
    finish_conv(16'hA5C3);
    chk("R2 sleep after done", {31'd0, sleep}, 1);
  endtask

  task automatic t_other_addr();
    logic ack;
    bus_start(); send_byte(8'h28, ack); bus_stop();
    chk("R5 write nak", {31'd0, ack}, 0);
    bus_start(); send_byte(8'h2B, ack); bus_stop();
    chk("R5 foreign addr nak", {31'd0, ack}, 0);
    chk("R5 sleep kept", {31'd0, sleep}, 1);
    chk("R5 no start", n_kick, 1);
  endtask

  task automatic t_full_read();
    logic ack; logic [15:0] v; int k0;
    finish_conv(16'h1234);
    conv_data = 16'h0F0F;
    k0 = n_kick;
    read_word(ack, v);
    chk("R3 ack in sleep", {31'd0, ack}, 1);
    chk("R6 R10 word msb first, held", {16'd0, v}, {16'd0, 16'hA5C3});
    chk("R7 one start after 16 bits", n_kick - k0, 1);
    chk("R7 sleep dropped", {31'd0, sleep}, 0);
  endtask

  task automatic t_rstart();
    logic ack; logic [7:0] hi, lo; int k0;
    finish_conv(16'h5A96);
    k0 = n_kick;
    bus_start(); send_byte(8'h29, ack);
    recv_byte(1'b1, hi);
    chk("R6 first byte", {24'd0, hi}, {24'd0, 8'h5A});
    bus_rstart();
    chk("R9 no start on rstart", n_kick - k0, 0);
    send_byte(8'h29, ack);
    chk("R9 ack after rstart", {31'd0, ack}, 1);
    recv_byte(1'b1, hi); recv_byte(1'b0, lo);
    bus_stop();
    chk("R9 same word again", {16'd0, hi, lo}, {16'd0, 16'h5A96});
    chk("R9 one start in total", n_kick - k0, 1);
  endtask

  task automatic t_stop_early();
    logic ack; int k0;
    finish_conv(16'hA5C3);
    k0 = n_kick;
    bus_start(); send_byte(8'h29, ack); bus_stop();
    chk("R8 acked", {31'd0, ack}, 1);
    chk("R8 start on stop", n_kick - k0, 1);
    chk("R8 sleep dropped", {31'd0, sleep}, 0);
    chk("R12 released after stop", {31'd0, sda_pull}, 0);
  endtask

  task automatic t_glitch();
    logic ack; logic [15:0] v;
    finish_conv(16'h6B2D);
    glitch = 1'b1;
    read_word(ack, v);
    glitch = 1'b0;
    chk("R11 ack despite spikes", {31'd0, ack}, 1);
    chk("R11 word despite spikes", {16'd0, v}, {16'd0, 16'h6B2D});
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    wq(5);
    rst_n = 1'b1;
    t_reset();
    t_busy_nak();
    t_done();
    t_other_addr();
    t_full_read();
    t_rstart();
    t_stop_early();
    t_glitch();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

endmodule